// File: doc/BRIEF.md
# Disk Interface Control and Interrupt Register Block

This block is the host-facing identification and control register set of a disk interface controller. The host reads a fixed identification word and reads and writes a status/control word. The status/control word holds the interrupt enable, a write-one interrupt clear, the bit that drives the drive's reset line, and a read-only pending flag. The drive's interrupt request arrives asynchronously. It passes through a synchronizer, and each rising edge latches the pending flag.

The pending flag is handled by a two-state machine. In state PS_CLEAR nothing is pending, and the transition "raise" to PS_PENDING happens on a synchronized rising edge. In state PS_PENDING the transition "drop" back to PS_CLEAR happens on one of three events: a write-one clear, a write of all zeros to the status/control word, or a strobe reporting that the drive's status register was read. A read of the alternate status register leaves the flag alone. Because the status read clears the flag, software does not see each interrupt twice. If a new edge arrives in the same cycle as a clear, the state stays in or enters PS_PENDING. The interrupt output is the pending flag gated by the enable.

The drive reset line is active low and follows the reset control bit. A software reset sequence therefore writes the bit high, then low, then high. The revision field of the identification word tells software whether the DMA register words exist: they do when the revision is 2 or more.

Top module: `disk_ctl_regs`

## Requirements
- R1: A read at byte offset 0x00 returns the identification word. Its layout is: bits [5:0] = 0x09, bits [7:6] = 0, bits [13:8] = 0x36, bits 14 and 15 = 1, bits [23:16] = the REV parameter, bits [31:24] = the CFG parameter. With the defaults (REV 2, CFG 0) the word is 0x0002F609.
- R2: After reset, `irq` is 0, `drv_reset_n` is 0, and the status/control word at offset 0x08 reads 0.
- R3: A rising edge on `drv_intrq` sets the pending flag (status/control bit 5) within three clock edges. A level that stays high does not set the flag again after it has been cleared.
- R4: `irq` is 1 exactly when the pending flag and the enable bit (status/control bit 0) are both 1.
- R5: Writing the status/control word with bit 1 = 1 clears the pending flag. Bit 1 always reads 0.
- R6: A pulse on `drv_stat_rd` clears the pending flag. A pulse on `drv_altstat_rd` leaves it unchanged.
- R7: If a synchronized rising edge and a clear occur in the same cycle, the pending flag ends up set.
- R8: `drv_reset_n` follows status/control bit 2 after each write: a written 0 asserts drive reset (line low) and a written 1 releases it. The bit reads back at position 2.
- R9: Writing 0 to the status/control word returns it to the reset state: enable 0, drive reset asserted, pending cleared.
- R10: Writes to offset 0x00 or to any unmapped offset change no state. Reads of unmapped offsets (for example 0x0C) return 0. Reads have no side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Write strobe for the host register access |
| host_addr | input | ADDR_W | Byte offset of the host access |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for the word at host_addr (combinational) |
| drv_stat_rd | input | 1 | One-cycle strobe: the drive status register was read |
| drv_altstat_rd | input | 1 | One-cycle strobe: the drive alternate status register was read |
| drv_intrq | input | 1 | Asynchronous interrupt request from the drive |
| irq | output | 1 | Interrupt output to the host |
| drv_reset_n | output | 1 | Active-low reset to the drive |

## Verification
The bench targets the collision in which a clear strobe lands in the cycle the synchronized edge is consumed. A design that lets the clear win would lose that interrupt and read bit 5 as 0. It also holds the request high across a clear: a level-sensitive latch would set the flag again and raise `irq` with no new event. The bench checks that an alternate-status strobe, a read, and writes to the ID or to unmapped offsets change nothing, since a wrong decode would drop the flag or corrupt the enable or reset bits. Random write values cover the all-zeros write separately from the bit-1 clear, so a design that treats zero as an ordinary write would keep a stale pending flag.

// File: rtl/disk_ctl_pkg.sv
package disk_ctl_pkg;
    typedef enum logic {
        PS_CLEAR   = 1'b0,
        PS_PENDING = 1'b1
    } pend_state_e;

    localparam int OFS_ID     = 'h00;
    localparam int OFS_TIMING = 'h04;
    localparam int OFS_SC     = 'h08;

    localparam int SC_IE_BIT   = 0;
    localparam int SC_CLR_BIT  = 1;
    localparam int SC_RST_BIT  = 2;
    localparam int SC_PEND_BIT = 5;

    localparam logic [5:0] ID_CODE  = 6'h09;
    localparam logic [5:0] ID_NCODE = 6'h36;
endpackage

// File: rtl/disk_intrq_sync.sv
module disk_intrq_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] chain_q;
    logic                   prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= async_in;
    end

    generate
        for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[g] <= 1'b0;
                else        chain_q[g] <= chain_q[g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[LAST];
    end

    assign rise = chain_q[LAST] & ~prev_q;

    // R3: an edge indication lasts a single cycle
    p_edge_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/disk_pend_fsm.sv
module disk_pend_fsm
    import disk_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_evt,
    output logic pending
);
    pend_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_CLEAR:   if (set_evt) state_d = PS_PENDING;
            PS_PENDING: if (clr_evt && !set_evt) state_d = PS_CLEAR;
            default:    state_d = PS_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PS_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        pending = (state_q == PS_PENDING);
    end

    // R7: a set in the same cycle as a clear leaves the flag set
    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> pending);
    // R5: a clear without a set drops the flag
    p_clear_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_evt && !set_evt) |=> !pending);
    // R10: without events the flag holds
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_evt && !set_evt) |=> $stable(pending));
endmodule

// File: rtl/disk_ctl_regs.sv
module disk_ctl_regs
    import disk_ctl_pkg::*;
#(
    parameter int         ADDR_W      = 8,
    parameter logic [7:0] REV         = 8'h02,
    parameter logic [7:0] CFG         = 8'h00,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    input  logic              drv_stat_rd,
    input  logic              drv_altstat_rd,
    input  logic              drv_intrq,
    output logic              irq,
    output logic              drv_reset_n
);
    localparam logic [ADDR_W-1:0] A_ID = ADDR_W'(OFS_ID);
    localparam logic [ADDR_W-1:0] A_SC = ADDR_W'(OFS_SC);
    localparam logic [31:0] ID_WORD = {CFG, REV, 2'b11, ID_NCODE, 2'b00, ID_CODE};

    logic ie_q, rst_ctl_q;
    logic rise, pending, wr_sc, clr_evt;
    logic unused_inputs;

    assign unused_inputs = ^{host_wdata[31:6], host_wdata[4:3], drv_altstat_rd};

    disk_intrq_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (drv_intrq),
        .rise     (rise)
    );

    assign wr_sc   = host_wr && (host_addr == A_SC);
    assign clr_evt = drv_stat_rd
                   || (wr_sc && (host_wdata[SC_CLR_BIT] || (host_wdata == 32'd0)));

    disk_pend_fsm u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (rise),
        .clr_evt (clr_evt),
        .pending (pending)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q      <= 1'b0;
            rst_ctl_q <= 1'b0;
        end else if (wr_sc) begin
            ie_q      <= host_wdata[SC_IE_BIT];
            rst_ctl_q <= host_wdata[SC_RST_BIT];
        end
    end

    always_comb begin
        host_rdata = 32'd0;
        if (host_addr == A_ID) begin
            host_rdata = ID_WORD;
        end else if (host_addr == A_SC) begin
            host_rdata[SC_IE_BIT]   = ie_q;
            host_rdata[SC_RST_BIT]  = rst_ctl_q;
            host_rdata[SC_PEND_BIT] = pending;
        end
    end

    assign irq         = pending & ie_q;
    assign drv_reset_n = rst_ctl_q;

    // R4: the output never fires with the enable off
    p_irq_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ie_q && pending));
    // R8: the reset line follows the written control bit
    p_reset_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sc |=> (drv_reset_n == $past(host_wdata[SC_RST_BIT])));
    // R9: writing zero leaves enable off and reset asserted
    p_zero_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sc && host_wdata == 32'd0) |=> (!irq && !drv_reset_n));
    // R10: writes elsewhere leave control bits unchanged
    p_other_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr != A_SC) |=> ($stable(ie_q) && $stable(rst_ctl_q)));
endmodule

// File: tb/sim_disk_ctl_regs.sv
module sim_disk_ctl_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [7:0]  host_addr = 8'h00;
    logic [31:0] host_wdata = 32'd0;
    logic [31:0] host_rdata;
    logic        drv_stat_rd = 1'b0;
    logic        drv_altstat_rd = 1'b0;
    logic        drv_intrq = 1'b0;
    logic        irq, drv_reset_n;

    int n_chk = 0;
    int n_bad = 0;
    bit m_pend = 0, m_ie = 0, m_rst = 0;

    always #10 clk = ~clk;

    disk_ctl_regs u0 (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .drv_stat_rd(drv_stat_rd), .drv_altstat_rd(drv_altstat_rd),
        .drv_intrq(drv_intrq), .irq(irq), .drv_reset_n(drv_reset_n)
    );

    function automatic logic [31:0] exp_sc(bit p, bit ie, bit r);
        return {26'd0, p, 2'b00, r, 1'b0, ie};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] v);
        @(negedge clk);
        host_addr = a; host_wdata = v; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic strobe(bit alt);
        @(negedge clk);
        if (alt) drv_altstat_rd = 1'b1; else drv_stat_rd = 1'b1;
        @(negedge clk);
        drv_altstat_rd = 1'b0; drv_stat_rd = 1'b0;
    endtask

    task automatic pulse_intrq();
        @(negedge clk);
        drv_intrq = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        drv_intrq = 1'b0;
        repeat (4) @(posedge clk);
    endtask

    task automatic check_all(string tag);
        logic [31:0] d;
        rd(8'h08, d);
        check({tag, " status word"}, d, exp_sc(m_pend, m_ie, m_rst));
        check({tag, " irq R4"}, {31'd0, irq}, {31'd0, m_pend & m_ie});
        check({tag, " reset line R8"}, {31'd0, drv_reset_n}, {31'd0, m_rst});
    endtask

    initial begin
        #3_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        check_all("R2 reset");
        rd(8'h00, d); check("R1 id word", d, 32'h0002F609);
        rd(8'h0C, d); check("R10 unmapped read", d, 32'd0);

        wr(8'h08, 32'h5); m_ie = 1; m_rst = 1;
        check_all("R8 release");

        // R3: edge sets pending, visible after three edges
        @(negedge clk) drv_intrq = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R3 irq after edge", {31'd0, irq}, 32'd1);
        m_pend = 1;
        check_all("R3 set");
        // R3: held level does not re-set after a clear (R5)
        wr(8'h08, 32'h7); m_pend = 0;
        repeat (6) @(posedge clk);
        check_all("R3 level held R5");
        @(negedge clk) drv_intrq = 1'b0;
        repeat (4) @(posedge clk);

        // R6: alt status read leaves it, status read clears it
        pulse_intrq(); m_pend = 1;
        strobe(1); check_all("R6 alt read");
        rd(8'h08, d); rd(8'h08, d); check_all("R10 read no effect");
        wr(8'h00, 32'h0); wr(8'h0C, 32'h2); wr(8'h04, 32'h0);
        check_all("R10 other writes");
        strobe(0); m_pend = 0; check_all("R6 status read");

        // R7: status-read strobe coincides with the consumed edge
        @(negedge clk) drv_intrq = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk) drv_stat_rd = 1'b1;
        @(posedge clk);
        @(negedge clk) drv_stat_rd = 1'b0;
        m_pend = 1;
        check_all("R7 set wins");
        @(negedge clk) drv_intrq = 1'b0;
        repeat (4) @(posedge clk);

        // R9: zero write returns to reset state
        wr(8'h08, 32'h0); m_pend = 0; m_ie = 0; m_rst = 0;
        check_all("R9 zero write");

        for (int i = 0; i < 80; i++) begin
            int op = $urandom_range(0, 4);
            case (op)
                0: begin
                    logic [31:0] v = ($urandom_range(0, 5) == 0) ? 32'd0 : ($urandom & 32'h25);
                    wr(8'h08, v);
                    if (v == 0 || v[1]) m_pend = 0;
                    m_ie = v[0]; m_rst = v[2];
                    check_all("R9 R5 random write");
                end
                1: begin
                    logic [31:0] v = $urandom | 32'h2;
                    wr(8'h08, v);
                    m_pend = 0; m_ie = v[0]; m_rst = v[2];
                    check_all("R5 random clear");
                end
                2: begin pulse_intrq(); m_pend = 1; check_all("R3 random edge"); end
                3: begin strobe(0); m_pend = 0; check_all("R6 random status rd"); end
                default: begin strobe(1); check_all("R6 random alt rd"); end
            endcase
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule